// File: doc/BRIEF.md
# Byte-Bus Loader for a Double-Buffered 12-Bit DAC

This block sits between an 8-bit processor write bus and a 12-bit converter whose input logic holds three 4-bit first-rank latches and one 12-bit second-rank latch. All of those latches are level-sensitive with active-low controls. The loader decodes each bus write into a registered, active-low chip select plus four active-low enables: one per first-rank nibble and one that copies the first rank into the second rank. It also places the right byte lane on the 12 converter data lines.

The loader takes up two adjacent bus addresses above a decoded base. The write to the lower address (offset 01) stages part of the word in the first rank. The write to the upper address (offset 10) fills in the rest of the word and copies it into the second rank, so the analog output moves only once per 12-bit value. A mode input selects one of two byte layouts. In the left-justified layout the top eight bits go in one byte and the bottom four bits go in the high half of the other byte. In the right-justified layout the low eight bits go in one byte and the top four bits go in the low half of the other byte.

Every output is a flop. Each decision the loader makes reaches the pins on the clock edge after the write and stays there for exactly that one cycle.

Top module: `byte_dac_loader`

## Requirements
- R1: After reset, `csN`, all three `nibEnN` bits and `xferN` are high, and `dacData` is zero.
- R2: `csN` goes low for one cycle, one clock after a write (`wrEn` high) whose address bits above bit 1 equal `BASE_HI`. A write to any other address leaves every output at its idle value.
- R3: Left mode (`rightJust`=0), offset 01: only `nibEnN[0]` (least significant nibble) goes low, and `dacData[3:0]` carries `busData[7:4]`.
- R4: Left mode, offset 10: `nibEnN[1]`, `nibEnN[2]` and `xferN` go low, and `dacData[11:4]` carries `busData[7:0]`.
- R5: Right mode (`rightJust`=1), offset 01: `nibEnN[0]` and `nibEnN[1]` go low, and `dacData[7:0]` carries `busData[7:0]`.
- R6: Right mode, offset 10: `nibEnN[2]` and `xferN` go low, and `dacData[11:8]` carries `busData[3:0]`.
- R7: A write to offset 00 or 11 under the base asserts no enable and loads no latch. The word already committed is left unchanged.
- R8: Each enable stays low for exactly one clock per accepted write. In a cycle after no write, all enables and `csN` are high.
- R9: A write to offset 10 commits even if no offset-01 write came before it. The committed word then takes its low-order part from whatever the first rank already holds.
- R10: Any `dacData` bit not covered by a low enable in that cycle is driven to zero.
- R11: No enable is ever low while `csN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Bus write strobe, one write per high cycle |
| busAddr | input | ADDR_W | Bus write address |
| busData | input | 8 | Bus write byte |
| rightJust | input | 1 | 0 = left-justified layout, 1 = right-justified layout |
| dacData | output | 12 | Converter data lines |
| csN | output | 1 | Active-low converter chip select |
| nibEnN | output | 3 | Active-low first-rank nibble enables, bit 0 = least significant nibble |
| xferN | output | 1 | Active-low second-rank load enable |

## Verification
The bench builds the loader with its defaults: an 8-bit address and base field 0x2A, so the pair of write addresses is 0xA9 and 0xAA. With only eight address bits, the bench can write to a neighbouring base and to every offset around the pair. The bench also models the converter's two latch ranks from the enables and data lines, which lets it check the committed 12-bit word for both layouts, for a commit with no offset-01 write before it, and for back-to-back writes.

// File: rtl/dacldr_pkg.sv
package dacldr_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int NIB_N  = 3;
  localparam int WORD_W = NIB_W * NIB_N;

  // strobes from decode to datapath
  typedef struct packed {
    logic             sel;        // base matched on a write
    logic [NIB_N-1:0] ldNib;      // first-rank nibbles to open
    logic             commit;     // open the second rank
    logic             upper;      // offset 10 write
    logic             rightMode;  // right-justified layout
  } loadStrb_t;
endpackage

// File: rtl/dacldr_ctrl.sv
module dacldr_ctrl
  import dacldr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-3:0] BASE_HI = 6'h2A
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              rightJust,
  output loadStrb_t         strb
);
  localparam int HI_W = ADDR_W - 2;

  logic       baseHit;
  logic [1:0] offset;
  logic       lowWr;
  logic       upWr;

  always_comb begin
    baseHit = (busAddr[ADDR_W-1:2] == BASE_HI[HI_W-1:0]);
    offset  = busAddr[1:0];
    lowWr   = (offset == 2'b01);
    upWr    = (offset == 2'b10);

    strb           = '0;
    strb.sel       = wrEn && baseHit;
    strb.upper     = upWr;
    strb.rightMode = rightJust;
    if (strb.sel && (lowWr || upWr)) begin
      strb.commit = upWr;
      unique case ({rightJust, upWr})
        2'b00:   strb.ldNib = 3'b001;
        2'b01:   strb.ldNib = 3'b110;
        2'b10:   strb.ldNib = 3'b011;
        default: strb.ldNib = 3'b100;
      endcase
    end
  end

  // R7: the two unused offsets never open a latch
  always_comb begin
    if (!lowWr && !upWr)
      assert_ignore_offset_R7: assert (strb.ldNib == '0 && !strb.commit);
  end
endmodule

// File: rtl/dacldr_dpath.sv
module dacldr_dpath
  import dacldr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  loadStrb_t         strb,
  input  logic [BYTE_W-1:0] busData,
  output logic [WORD_W-1:0] dacData,
  output logic              csN,
  output logic [NIB_N-1:0]  nibEnN,
  output logic              xferN
);
  localparam int PAD_HI = WORD_W - BYTE_W;   // 4
  localparam int PAD_LO = WORD_W - NIB_W;    // 8

  logic [WORD_W-1:0] wordNext;

  always_comb begin
    if (strb.ldNib == '0) begin
      wordNext = '0;
    end else begin
      unique case ({strb.rightMode, strb.upper})
        2'b00:   wordNext = {{PAD_LO{1'b0}}, busData[BYTE_W-1:NIB_W]};
        2'b01:   wordNext = {busData, {PAD_HI{1'b0}}};
        2'b10:   wordNext = {{PAD_HI{1'b0}}, busData};
        default: wordNext = {busData[NIB_W-1:0], {PAD_LO{1'b0}}};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacData <= '0;
      csN     <= 1'b1;
      xferN   <= 1'b1;
    end else begin
      dacData <= wordNext;
      csN     <= !strb.sel;
      xferN   <= !(strb.sel && strb.commit);
    end
  end

  for (genvar i = 0; i < NIB_N; i++) begin : g_nibEn
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) nibEnN[i] <= 1'b1;
      else       nibEnN[i] <= !(strb.sel && strb.ldNib[i]);
    end
  end

  assert_en_needs_cs_R11: assert property (@(posedge clk) disable iff (!rstN)
    (nibEnN != '1 || !xferN) |-> !csN);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.sel |=> (csN && nibEnN == '1 && xferN));

  assert_commit_with_msn_R6: assert property (@(posedge clk) disable iff (!rstN)
    !xferN |-> !nibEnN[NIB_N-1]);

  assert_zero_fill_R10: assert property (@(posedge clk) disable iff (!rstN)
    (nibEnN == '1) |-> (dacData == '0));

  assert_left_lsn_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sel && !strb.rightMode && strb.ldNib == 3'b001)
      |=> (dacData[NIB_W-1:0] == $past(busData[BYTE_W-1:NIB_W])));
endmodule

// File: rtl/byte_dac_loader.sv
module byte_dac_loader
  import dacldr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-3:0] BASE_HI = 6'h2A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busData,
  input  logic              rightJust,
  output logic [11:0]       dacData,
  output logic              csN,
  output logic [2:0]        nibEnN,
  output logic              xferN
);
  loadStrb_t strb;

  dacldr_ctrl #(.ADDR_W(ADDR_W), .BASE_HI(BASE_HI)) ctrl_i (
    .wrEn(wrEn), .busAddr(busAddr), .rightJust(rightJust), .strb(strb)
  );

  dacldr_dpath dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busData(busData),
    .dacData(dacData), .csN(csN), .nibEnN(nibEnN), .xferN(xferN)
  );
endmodule

// File: tb/byte_dac_loader_tb_top.sv
module byte_dac_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] LOW_ADDR = 8'hA9;
  localparam logic [7:0] UP_ADDR  = 8'hAA;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [7:0]  busData = '0;
  logic        rightJust = 1'b0;
  logic [11:0] dacData;
  logic        csN;
  logic [2:0]  nibEnN;
  logic        xferN;

  int checks = 0;
  int fails = 0;
  logic [11:0] firstRank = '0;
  logic [11:0] secondRank = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_dac_loader dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .busAddr(busAddr), .busData(busData),
    .rightJust(rightJust), .dacData(dacData), .csN(csN), .nibEnN(nibEnN), .xferN(xferN)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // converter latch model driven only by the loader outputs
  task automatic modelLatch();
    if (!csN) begin
      for (int i = 0; i < 3; i++)
        if (!nibEnN[i]) firstRank[i*4 +: 4] = dacData[i*4 +: 4];
      if (!xferN) secondRank = firstRank;
    end
  endtask

  task automatic checkPins(input string tag, input logic expCs, input logic [2:0] expEn,
                           input logic expX, input logic [11:0] expD);
    chk(csN == expCs, {tag, " csN"}, {15'd0, csN}, {15'd0, expCs});
    chk(nibEnN == expEn, {tag, " nibEnN"}, {13'd0, nibEnN}, {13'd0, expEn});
    chk(xferN == expX, {tag, " xferN"}, {15'd0, xferN}, {15'd0, expX});
    chk(dacData == expD, {tag, " dacData"}, {4'd0, dacData}, {4'd0, expD});
  endtask

  // one write cycle; returns at the negedge where its result is visible
  task automatic doWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; busAddr = a; busData = d;
    @(negedge clk);
    wrEn = 1'b0;
    modelLatch();
  endtask

  task automatic idleCheck(input string tag);
    @(negedge clk);
    modelLatch();
    checkPins(tag, 1'b1, 3'b111, 1'b1, 12'h000);
  endtask

  task automatic t_reset();
    checkPins("R1 reset", 1'b1, 3'b111, 1'b1, 12'h000);
  endtask

  task automatic t_left_pair();
    rightJust = 1'b0;
    doWrite(LOW_ADDR, 8'h5C);
    checkPins("R3 left low", 1'b0, 3'b110, 1'b1, 12'h005);
    idleCheck("R8 release after low");
    doWrite(UP_ADDR, 8'hE3);
    checkPins("R4 left up", 1'b0, 3'b001, 1'b0, 12'hE30);
    chk(secondRank == 12'hE35, "R4 left committed word", {4'd0, secondRank}, 16'h0E35);
    idleCheck("R8 release after up");
  endtask

  task automatic t_right_pair();
    rightJust = 1'b1;
    doWrite(LOW_ADDR, 8'h7B);
    checkPins("R5 right low", 1'b0, 3'b100, 1'b1, 12'h07B);
    chk(secondRank == 12'hE35, "R5 no commit on low write", {4'd0, secondRank}, 16'h0E35);
    doWrite(UP_ADDR, 8'h3D);
    checkPins("R6 right up", 1'b0, 3'b011, 1'b0, 12'hD00);
    chk(secondRank == 12'hD7B, "R6 right committed word", {4'd0, secondRank}, 16'h0D7B);
  endtask

  task automatic t_ignored();
    doWrite(8'hA8, 8'hFF);
    checkPins("R7 offset 00", 1'b0, 3'b111, 1'b1, 12'h000);
    doWrite(8'hAB, 8'hFF);
    checkPins("R7 offset 11", 1'b0, 3'b111, 1'b1, 12'h000);
    chk(secondRank == 12'hD7B, "R7 word kept", {4'd0, secondRank}, 16'h0D7B);
    chk(firstRank == 12'hD7B, "R7 first rank kept", {4'd0, firstRank}, 16'h0D7B);
  endtask

  task automatic t_wrong_base();
    doWrite(8'h29, 8'hAA);
    checkPins("R2 other base", 1'b1, 3'b111, 1'b1, 12'h000);
    doWrite(8'hAE, 8'h11);
    checkPins("R2 neighbour base", 1'b1, 3'b111, 1'b1, 12'h000);
  endtask

  task automatic t_commit_only();
    rightJust = 1'b1;
    doWrite(UP_ADDR, 8'h09);
    checkPins("R9 commit alone", 1'b0, 3'b011, 1'b0, 12'h900);
    chk(secondRank == 12'h97B, "R9 stale low bits", {4'd0, secondRank}, 16'h097B);
  endtask

  task automatic t_back_to_back();
    rightJust = 1'b0;
    @(negedge clk);
    wrEn = 1'b1; busAddr = LOW_ADDR; busData = 8'hA0;
    @(negedge clk);
    modelLatch();
    checkPins("R8 b2b first", 1'b0, 3'b110, 1'b1, 12'h00A);
    busAddr = UP_ADDR; busData = 8'h4C;
    @(negedge clk);
    wrEn = 1'b0;
    modelLatch();
    checkPins("R8 b2b second", 1'b0, 3'b001, 1'b0, 12'h4C0);
    chk(secondRank == 12'h4CA, "R10 b2b committed word", {4'd0, secondRank}, 16'h04CA);
    idleCheck("R8 b2b release");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_left_pair();
    t_right_pair();
    t_ignored();
    t_wrong_base();
    t_commit_only();
    t_back_to_back();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (10000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule